// File: doc/BRIEF.md
# String Transfer Address Sequencer

This block sequences memory accesses for string-style element transfers. It holds a source index, a destination index and an accumulator. On each issued command it runs one element, or a counted run of elements, of three kinds. A load reads memory into the accumulator. A store writes the accumulator to memory. A move copies memory to memory. Element width is one, two or four bytes.

Every access leaves on a single request/acknowledge port. The port carries a one-bit segment tag that tells the downstream address unit which segment base to add to the offset. The indexes step by the element width after each element. A direction input selects whether they count up or down.

A command is accepted only while the block is idle. The index and accumulator registers can be loaded through a small write port while the block is idle, and they are always visible on outputs.

Top module: `strseq_top`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `mem_req` are 0, and `src_idx`, `dst_idx`, `acc` and `rep_cnt` are all 0.
- R2: While `busy` is 0, `wr_en` loads `wr_data` into the register picked by `wr_sel` (0 = source index, 1 = destination index, 2 = accumulator, 3 = nothing), visible the cycle after the edge. While `busy` is 1, `wr_en` has no effect.
- R3: A load (`cmd_op` = 2'b01) issues a read (`mem_we` = 0) with `mem_seg` = 0 at `mem_addr` = source index. On acknowledge it replaces only the low 8, 16 or 32 bits of `acc` with the matching low bits of `mem_rdata`, and the other bits of `acc` keep their value.
- R4: A store (`cmd_op` = 2'b10) issues a write (`mem_we` = 1) with `mem_seg` = 1 at `mem_addr` = destination index. `mem_wdata` is the low element-width bits of `acc`, with the upper bits 0.
- R5: A move (`cmd_op` = 2'b11) first reads at the source index with segment 0. Only after that read is acknowledged does it write at the destination index with segment 1. The write data is the element-width slice of the read data. Both indexes step on the edge that completes the write.
- R6: `cmd_size` 0, 1 and 2 select elements of 1, 2 and 4 bytes, and code 3 behaves as 4 bytes. `mem_size` carries the code. Each index step adds the element width when `cmd_dir` = 0 and subtracts it when `cmd_dir` = 1, wrapping modulo 2^32.
- R7: A load never changes the destination index. A store never changes the source index. A move leaves `acc` unchanged. `cmd_op` = 2'b00 makes no access and changes no index or accumulator.
- R8: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_seg` unchanged until the cycle in which `mem_ack` is 1.
- R9: With `cmd_rep` = 1, `rep_cnt` is loaded from `cmd_count` at issue and decremented once per completed element. The run stops when it reaches 0. A count of 0 at issue makes no access. With `cmd_rep` = 0 exactly one element runs and `rep_cnt` is left unchanged.
- R10: `busy` rises the cycle after the issuing edge and falls after the edge that completes the last element. `done` is a one-cycle pulse in the first cycle with `busy` low. `cmd_valid` while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register load strobe (idle only) |
| wr_sel | input | 2 | Register select: 0 source, 1 destination, 2 accumulator |
| wr_data | input | 32 | Register load value |
| cmd_valid | input | 1 | Issue a command (idle only) |
| cmd_op | input | 2 | Bit 0 = read phase, bit 1 = write phase |
| cmd_size | input | 2 | Element width code |
| cmd_dir | input | 1 | 0 = step up, 1 = step down |
| cmd_rep | input | 1 | Repeat using cmd_count |
| cmd_count | input | 32 | Element count for repeat |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_seg | output | 1 | 0 = data segment, 1 = extra segment |
| mem_addr | output | 32 | Offset within the tagged segment |
| mem_size | output | 2 | Element width code of the access |
| mem_wdata | output | 32 | Write data, zero above the element |
| mem_ack | input | 1 | Completes the pending request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| src_idx | output | 32 | Source index register |
| dst_idx | output | 32 | Destination index register |
| acc | output | 32 | Accumulator |
| rep_cnt | output | 32 | Remaining repeat count |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |

## Verification
The hardest states to reach from the ports are a request left waiting across several cycles, register writes and fresh commands arriving mid-run, and indexes crossing the 32-bit wrap. The bench's memory responder withholds acknowledge at random, so requests sit pending for varied stretches. Some runs deliberately pulse a register write and a competing command in the first busy cycle, then check that the final registers show no trace of them. Directed cases start an index at zero and step it downward, and issue repeat runs with a zero count.

// File: rtl/strseq_pkg.sv
// Shared types and helpers for the string transfer sequencer.
// Assumes a 32-bit accumulator; index and count widths are parameters of the top.
package strseq_pkg;
    localparam int ACC_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ELEM = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_state_e;

    localparam logic SEG_DATA  = 1'b0;
    localparam logic SEG_EXTRA = 1'b1;

    // Mask of the accumulator bits covered by an element of the given size code
    function automatic logic [ACC_W-1:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    lane_mask = 32'h0000_00FF;
            2'd1:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/strseq_step.sv
// Index stepper: next index value for one element of the given size and direction.
// Assumes size code 3 behaves as 4 bytes; wrap is natural modulo 2^IDX_W.
module strseq_step #(
    parameter int IDX_W = 32
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       size_i,
    input  logic             dir_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] mag;

    // Element width in bytes from the size code
    always_comb begin
        case (size_i)
            2'd0:    mag = IDX_W'(1);
            2'd1:    mag = IDX_W'(2);
            default: mag = IDX_W'(4);
        endcase
    end

    // Direction picks add or subtract
    always_comb idx_o = dir_i ? (idx_i - mag) : (idx_i + mag);
endmodule

// File: rtl/strseq_lane.sv
// Accumulator lane unit: merges read data into the low element slice of the
// accumulator and forms the masked write data for stores and moves.
// Assumes the move buffer already holds a masked element.
module strseq_lane
    import strseq_pkg::*;
(
    input  logic [1:0]       size_i,
    input  logic             move_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] rdata_i,
    input  logic [ACC_W-1:0] buf_i,
    output logic [ACC_W-1:0] acc_merged_o,
    output logic [ACC_W-1:0] rd_slice_o,
    output logic [ACC_W-1:0] wdata_o
);
    logic [ACC_W-1:0] mask;

    // Element mask from size
    always_comb mask = lane_mask(size_i);

    // Slice insertion for loads, slice extraction for moves
    always_comb begin
        rd_slice_o   = rdata_i & mask;
        acc_merged_o = (acc_i & ~mask) | rd_slice_o;
    end

    // Write data source: move buffer or accumulator slice
    always_comb wdata_o = move_i ? buf_i : (acc_i & mask);
endmodule

// File: rtl/strseq_ctrl.sv
// Sequencer control: accepts a command while idle, then walks each element
// through an optional read phase and an optional write phase, and issues
// register update strobes. Assumes mem_ack is only meaningful while mem_req is high.
module strseq_ctrl
    import strseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [1:0] cmd_size,
    input  logic       cmd_dir,
    input  logic       cmd_rep,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    input  logic       mem_ack,
    output logic       busy,
    output logic       done,
    output logic       mem_req,
    output logic       mem_we,
    output logic       mem_seg,
    output logic [1:0] op_q,
    output logic [1:0] size_q,
    output logic       dir_q,
    output logic       issue,
    output logic       ld_acc,
    output logic       ld_buf,
    output logic       step_src,
    output logic       step_dst,
    output logic       cnt_dec
);
    seq_state_e state;
    logic       rep_q;
    logic       elem_end;

    // An element completes on an acked read of a load or any acked write
    always_comb elem_end = mem_ack && ((state == ST_RD && !op_q[1]) || state == ST_WR);

    // State and command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= 2'b00;
            size_q <= 2'b00;
            dir_q  <= 1'b0;
            rep_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q   <= cmd_op;
                        size_q <= cmd_size;
                        dir_q  <= cmd_dir;
                        rep_q  <= cmd_rep;
                        state  <= ST_ELEM;
                    end
                end
                ST_ELEM: begin
                    if (op_q == 2'b00 || (rep_q && cnt_zero)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (op_q[0]) begin
                        state <= ST_RD;
                    end else begin
                        state <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (mem_ack && op_q[1]) state <= ST_WR;
                end
                default: ;
            endcase
            if (elem_end) begin
                if (rep_q && !cnt_one) begin
                    state <= ST_ELEM;
                end else begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    // Memory request signals from state
    always_comb begin
        mem_req = (state == ST_RD) || (state == ST_WR);
        mem_we  = (state == ST_WR);
        mem_seg = (state == ST_WR) ? SEG_EXTRA : SEG_DATA;
        busy    = (state != ST_IDLE);
    end

    // Register update strobes
    always_comb begin
        issue    = (state == ST_IDLE) && cmd_valid;
        ld_acc   = (state == ST_RD) && mem_ack && !op_q[1];
        ld_buf   = (state == ST_RD) && mem_ack && op_q[1];
        step_src = ld_acc || ((state == ST_WR) && mem_ack && op_q[0]);
        step_dst = (state == ST_WR) && mem_ack;
        cnt_dec  = rep_q && elem_end;
    end

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: done is reported only once busy has dropped
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5: a move writes only after its read has been acknowledged
    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && op_q == 2'b11) |=> (mem_req && mem_we));
endmodule

// File: rtl/strseq_top.sv
// String transfer address sequencer top: holds the source and destination
// indexes, the accumulator, the move buffer and the repeat counter, and drives
// the memory request port. Assumes a single outstanding memory request.
module strseq_top
    import strseq_pkg::*;
#(
    parameter int IDX_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [1:0]       cmd_size,
    input  logic             cmd_dir,
    input  logic             cmd_rep,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_seg,
    output logic [IDX_W-1:0] mem_addr,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [IDX_W-1:0] src_idx,
    output logic [IDX_W-1:0] dst_idx,
    output logic [31:0]      acc,
    output logic [CNT_W-1:0] rep_cnt,
    output logic             busy,
    output logic             done
);
    localparam int N_IDX = 2;

    logic [1:0]       op_q;
    logic [1:0]       size_q;
    logic             dir_q;
    logic             issue, ld_acc, ld_buf, step_src, step_dst, cnt_dec;
    logic [IDX_W-1:0] idx_q   [N_IDX];
    logic [IDX_W-1:0] idx_nxt [N_IDX];
    logic [N_IDX-1:0] step_en;
    logic [ACC_W-1:0] acc_q, buf_q, acc_merged, rd_slice, wdata;
    logic [CNT_W-1:0] cnt_q;

    strseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_size (cmd_size),
        .cmd_dir  (cmd_dir),
        .cmd_rep  (cmd_rep),
        .cnt_zero (cnt_q == '0),
        .cnt_one  (cnt_q == CNT_W'(1)),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .done     (done),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_seg  (mem_seg),
        .op_q     (op_q),
        .size_q   (size_q),
        .dir_q    (dir_q),
        .issue    (issue),
        .ld_acc   (ld_acc),
        .ld_buf   (ld_buf),
        .step_src (step_src),
        .step_dst (step_dst),
        .cnt_dec  (cnt_dec)
    );

    strseq_lane u_lane (
        .size_i      (size_q),
        .move_i      (op_q == 2'b11),
        .acc_i       (acc_q),
        .rdata_i     (mem_rdata),
        .buf_i       (buf_q),
        .acc_merged_o(acc_merged),
        .rd_slice_o  (rd_slice),
        .wdata_o     (wdata)
    );

    // Step enables per index: 0 source, 1 destination
    always_comb step_en = {step_dst, step_src};

    // One stepper and one register per index; write-port select equals index number
    for (genvar g = 0; g < N_IDX; g++) begin : g_idx
        strseq_step #(.IDX_W(IDX_W)) u_step (
            .idx_i (idx_q[g]),
            .size_i(size_q),
            .dir_i (dir_q),
            .idx_o (idx_nxt[g])
        );

        // Index register: software load while idle, element step while busy
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[g] <= '0;
            end else if (!busy && wr_en && wr_sel == 2'(g)) begin
                idx_q[g] <= IDX_W'(wr_data);
            end else if (step_en[g]) begin
                idx_q[g] <= idx_nxt[g];
            end
        end
    end

    // Accumulator and move buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            buf_q <= '0;
        end else begin
            if (!busy && wr_en && wr_sel == 2'd2) acc_q <= wr_data;
            else if (ld_acc)                      acc_q <= acc_merged;
            if (ld_buf) buf_q <= rd_slice;
        end
    end

    // Repeat counter: loaded at a repeat issue, decremented per element
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (issue && cmd_rep) cnt_q <= cmd_count;
        else if (cnt_dec)          cnt_q <= cnt_q - CNT_W'(1);
    end

    // Output mapping
    always_comb begin
        mem_addr  = mem_we ? idx_q[1] : idx_q[0];
        mem_size  = size_q;
        mem_wdata = wdata;
        src_idx   = idx_q[0];
        dst_idx   = idx_q[1];
        acc       = acc_q;
        rep_cnt   = cnt_q;
    end

    // R8: a pending request holds its attributes until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_seg)));
    // R10: requests only appear while busy
    a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R7: an operation without a read phase never moves the source index
    a_r7_src_still: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q[0]) |=> $stable(src_idx));
    // R7: an operation without a write phase never moves the destination index
    a_r7_dst_still: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q[1]) |=> $stable(dst_idx));
    // R9: while busy the count only holds or drops by one
    a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rep_cnt == $past(rep_cnt) || rep_cnt == $past(rep_cnt) - CNT_W'(1)));
    // R2: register writes are locked out while busy
    a_r2_acc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q != 2'b01) |=> $stable(acc));
endmodule

// File: tb/strseq_top_tb.sv
// Self-checking bench: directed corners plus seeded random commands, with a
// memory responder that delays acknowledge at random.
module strseq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        cmd_valid;
    logic [1:0]  cmd_op, cmd_size;
    logic        cmd_dir, cmd_rep;
    logic [31:0] cmd_count;
    logic        mem_req, mem_we, mem_seg, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic [31:0] src_idx, dst_idx, acc, rep_cnt;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    logic [31:0] cnt_model = 0;

    always #2.5 clk = ~clk;

    strseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_dir(cmd_dir),
        .cmd_rep(cmd_rep), .cmd_count(cmd_count), .mem_req(mem_req), .mem_we(mem_we),
        .mem_seg(mem_seg), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .src_idx(src_idx), .dst_idx(dst_idx),
        .acc(acc), .rep_cnt(rep_cnt), .busy(busy), .done(done)
    );

    function automatic logic [31:0] memf(input logic [31:0] a, input logic s);
        return (a * 32'h9E37_79B1) ^ (s ? 32'h5A5A_0000 : 32'h0) ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] fmask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] fstep(input logic [1:0] sz, input logic d);
        logic [31:0] m;
        m = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        return d ? -m : m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Run one command and check every access and the final register state
    task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic d,
                          input logic rep, input logic [31:0] cnt,
                          input logic [31:0] s0, input logic [31:0] d0,
                          input logic [31:0] a0, input bit poke);
        logic [31:0] st, es, ed, m_buf, n, nrd, nwr, exp_src, exp_dst, exp_acc, last;
        bit finished;
        write_reg(2'd0, s0);
        write_reg(2'd1, d0);
        write_reg(2'd2, a0);
        check("R2 src load", src_idx, s0);
        check("R2 dst load", dst_idx, d0);
        check("R2 acc load", acc, a0);
        st = fstep(sz, d);
        es = s0; ed = d0; m_buf = 0; nrd = 0; nwr = 0; finished = 0;
        n = (op == 2'b00) ? 0 : (rep ? cnt : 1);
        cmd_op = op; cmd_size = sz; cmd_dir = d; cmd_rep = rep; cmd_count = cnt;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 busy after issue", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 4000 && !finished; k++) begin
            if (poke && k == 0) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'hDEAD_BEEF;
                cmd_valid = 1'b1; cmd_op = 2'b11; cmd_rep = 1'b1; cmd_count = 32'd9;
            end else begin
                wr_en = 1'b0; cmd_valid = 1'b0;
            end
            if (done) begin
                finished = 1;
            end else begin
                if (mem_req) begin
                    mem_ack = ($urandom % 4) != 0;
                    mem_rdata = memf(mem_addr, mem_seg);
                    #1;
                    if (mem_ack) begin
                        check("R6 size tag", {30'd0, mem_size}, {30'd0, sz});
                        if (!mem_we) begin
                            check("R3 read segment", {31'd0, mem_seg}, 32'd0);
                            check("R3 read address", mem_addr, es);
                            if (op == 2'b11) m_buf = memf(es, 1'b0) & fmask(sz);
                            es = es + st; nrd++;
                        end else begin
                            check("R4 write segment", {31'd0, mem_seg}, 32'd1);
                            check("R4 write address", mem_addr, ed);
                            if (op == 2'b11) begin
                                check("R5 read before write", nrd, nwr + 1);
                                check("R5 move data", mem_wdata, m_buf);
                            end else begin
                                check("R4 store data", mem_wdata, a0 & fmask(sz));
                            end
                            ed = ed + st; nwr++;
                        end
                    end
                end else begin
                    mem_ack = 1'b0;
                end
                @(negedge clk);
            end
        end
        mem_ack = 1'b0; wr_en = 1'b0; cmd_valid = 1'b0;
        check("R10 done seen", {31'd0, finished}, 32'd1);
        check("R10 busy low at done", {31'd0, busy}, 32'd0);
        exp_src = op[0] ? s0 + n * st : s0;
        exp_dst = op[1] ? d0 + n * st : d0;
        exp_acc = a0;
        if (op == 2'b01 && n != 0) begin
            last = s0 + (n - 1) * st;
            exp_acc = (a0 & ~fmask(sz)) | (memf(last, 1'b0) & fmask(sz));
        end
        if (rep) cnt_model = cnt - n;
        check("R9 read count", nrd, op[0] ? n : 0);
        check("R9 write count", nwr, op[1] ? n : 0);
        check("R6 R7 source index", src_idx, exp_src);
        check("R6 R7 destination index", dst_idx, exp_dst);
        check("R3 R7 accumulator", acc, exp_acc);
        check("R9 repeat count", rep_cnt, cnt_model);
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 0;
        cmd_valid = 1'b0; cmd_op = 0; cmd_size = 0; cmd_dir = 0; cmd_rep = 0; cmd_count = 0;
        mem_ack = 1'b0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 src", src_idx, 32'd0);
        check("R1 dst", dst_idx, 32'd0);
        check("R1 acc", acc, 32'd0);
        check("R1 count", rep_cnt, 32'd0);

        // R3: byte load keeps upper accumulator bits
        run_op(2'b01, 2'd0, 1'b0, 1'b0, 32'd0, 32'h0000_1000, 32'h2000, 32'hA1B2_C3D4, 0);
        // R4: word store stepping down
        run_op(2'b10, 2'd1, 1'b1, 1'b0, 32'd0, 32'h10, 32'h0000_3000, 32'h1234_5678, 0);
        // R5 R9: repeated dword move
        run_op(2'b11, 2'd2, 1'b0, 1'b1, 32'd3, 32'h100, 32'h800, 32'h55, 0);
        // R9: zero count performs nothing
        run_op(2'b11, 2'd1, 1'b0, 1'b1, 32'd0, 32'h40, 32'h80, 32'h77, 0);
        // R7: no-phase op
        run_op(2'b00, 2'd2, 1'b0, 1'b0, 32'd0, 32'h44, 32'h88, 32'h99, 0);
        // R6: wrap below zero with size code 3
        run_op(2'b01, 2'd3, 1'b1, 1'b1, 32'd2, 32'h0, 32'h0, 32'hFFFF_0000, 0);
        // R2 R10: write and command during busy are ignored
        run_op(2'b10, 2'd0, 1'b0, 1'b1, 32'd2, 32'h5, 32'hFFFF_FFFF, 32'h0BAD_F00D, 1);
        run_op(2'b01, 2'd1, 1'b0, 1'b0, 32'd0, 32'h60, 32'h70, 32'h8765_4321, 1);

        for (int i = 0; i < 40; i++) begin
            logic [1:0] rop, rsz;
            rop = 2'($urandom % 4);
            rsz = 2'($urandom % 4);
            run_op(rop, rsz, 1'($urandom % 2), 1'($urandom % 2), $urandom % 5,
                   $urandom, $urandom, $urandom, ($urandom % 5) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule